// File: doc/BRIEF.md
# Oversampled UART serial engine

This block is the bit-level core of an asynchronous serial port. It turns bytes taken from a transmit queue into framed serial characters on a single line. It also recovers characters from an incoming line and hands each one to a receive queue, with an error flag for each kind of fault. All timing comes from a single-cycle enable, `tick`, which a separate divider pulses eight times per bit period. The engine never counts raw clock cycles.

Static configuration inputs set the frame shape:

- word length of seven or eight bits;
- one or two transmit stop bits;
- a parity bit, on or off, with four ways of choosing its value.

A loopback switch feeds the transmitter's output straight into the receiver. Two busy outputs show whether a frame is in progress in each direction. The queues, the register file and the baud divider all sit outside this block. The engine only pops the transmit queue and pushes to the receive queue.

Top module: `uart_os8_engine`

## Requirements
- R1: After reset, `tx_line` is high, `tx_active` and `rx_active` are low and `rx_push` is low. Whenever `tx_active` is low, `tx_line` is high.
- R2: Every transmitted bit lasts exactly eight `tick` pulses, and `tx_line` changes only on a clock edge where `tick` is high.
- R3: On a `tick` with `tx_valid` high and the transmitter free, the engine captures `tx_data` and pulses `tx_pop` high for one cycle on the following cycle. It then sends, in this order:
  - one low start bit;
  - the data bits, least significant first;
  - the parity bit, if enabled;
  - the high stop bit(s).
  A byte already waiting when the last stop bit ends starts on that same tick, with no idle gap.
- R4: With `cfg_data8` = 0 the frame carries 7 data bits: `tx_data[7]` is not sent and `rx_data[7]` is 0. With `cfg_data8` = 1 it carries 8.
- R5: With `cfg_stop2` = 1 the transmitter sends two stop bits. The receiver always checks only the first stop bit, so a new start bit may follow a single stop bit.
- R6: When `cfg_par_en` = 1, a parity bit follows the data. Its value depends on `cfg_par_mode`:
  - 0: odd parity;
  - 1: even parity;
  - 2: always 0;
  - 3: always 1.
  The parity is computed over the 7 or 8 data bits sent. When `cfg_par_en` = 0, no parity bit is sent.
- R7: When the received parity bit differs from the value R6 gives for the received data, the character is pushed with `rx_par_err` = 1.
- R8: A character whose first stop bit samples low, with at least one earlier bit high, is pushed with `rx_frm_err` = 1. The receiver then waits for the line to go high before it accepts a new start bit.
- R9: If every sampled bit of a frame is low, including the stop position, the character is pushed as a break: `rx_brk` = 1, `rx_data` = 0, `rx_par_err` = 0 and `rx_frm_err` = 0. No further character is accepted until the line returns high.
- R10: The receiver samples each bit on the fourth tick after the start edge is seen, then every eighth tick after that. A start bit found high at its sample point is dropped: no push occurs and `rx_active` returns low.
- R11: With `cfg_loop` = 1, the receiver hears `tx_line`, which is still driven at the port, and ignores `rx_line` entirely.
- R12: `tx_active` is high from the loading tick until the end of the last stop bit. `rx_active` is high from start-edge detection until the stop-bit sample, and low in the cycle `rx_push` is high.
- R13: `rx_push` is a single-cycle pulse. It carries `rx_data`, `rx_par_err`, `rx_frm_err` and `rx_brk` for exactly one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 8 pulses per bit |
| cfg_data8 | input | 1 | 1: 8-bit words, 0: 7-bit words |
| cfg_stop2 | input | 1 | 1: two transmit stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 zero, 3 one |
| cfg_loop | input | 1 | Internal loopback from transmitter to receiver |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Byte at the head of the transmit queue |
| tx_pop | output | 1 | One-cycle pop of the transmit queue |
| tx_line | output | 1 | Serial output, idle high |
| tx_active | output | 1 | Transmit frame in progress |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_push | output | 1 | One-cycle push of a received character |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frm_err | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Line held low for a whole frame |
| rx_active | output | 1 | Receive frame in progress |

## Verification
The bench samples `tx_line` at the centre of every bit, so several faults show up as a wrong bit at a known position:

- a reversed bit order or an odd/even swap in the parity encoder;
- a bit period other than eight ticks;
- a missing second stop bit, which also shows as `tx_active` falling one bit early.

Externally driven frames cover the rest:

- Flipped parity: a receiver that skips the check pushes a clean character.
- A low stop bit after a non-zero byte: a receiver that skips the stop check pushes a clean character.
- A line held low for more than a frame: a receiver without a wait-for-high stage would report several breaks.
- A short low glitch: a receiver that samples too early, or never checks the start bit, would push a phantom character.

Loopback frames are sent with the external input held low, so a loopback mux that leaks the pin produces breaks instead of data.

// File: rtl/uart_os8_pkg.sv
package uart_os8_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ZERO  = 2'd2,
    PAR_ONE   = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic      data8;
    logic      stop2;
    logic      par_en;
    par_mode_e par_mode;
  } line_cfg_t;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RUN  = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_e;

  // Parity bit from the XOR of the data bits and the selected mode.
  function automatic logic par_from_xor(input logic x, input par_mode_e m);
    unique case (m)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_ZERO: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uart_os8_tx.sv
module uart_os8_tx
  import uart_os8_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  line_cfg_t     cfg,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_pop,
  output logic          tx_line,
  output logic          tx_active
);
  localparam int FW = DW + 4;            // start + data + parity + 2 stop
  localparam int NW = $clog2(FW + 1);
  localparam int CW = $clog2(OS);

  logic [FW-1:0] sh;
  logic [FW-1:0] frame;
  logic [NW-1:0] left;
  logic [NW-1:0] flen;
  logic [NW-1:0] dlen;
  logic [CW-1:0] tc;
  logic [DW-1:0] md;
  logic          pbit;
  logic          bit_end;
  logic          can_load;

  always_comb begin
    dlen = cfg.data8 ? NW'(DW) : NW'(DW - 1);
    md   = tx_data;
    if (!cfg.data8) md[DW-1] = 1'b0;
    pbit = par_from_xor(^md, cfg.par_mode);
    frame = '1;
    frame[DW:0] = {md, 1'b0};
    if (!cfg.data8)       frame[DW]   = cfg.par_en ? pbit : 1'b1;
    else if (cfg.par_en)  frame[DW+1] = pbit;
    flen = dlen + NW'(2) + NW'(cfg.par_en) + NW'(cfg.stop2);
  end

  assign bit_end  = tick && tx_active && (tc == CW'(OS - 1));
  assign can_load = tick && tx_valid && (!tx_active || (bit_end && left == NW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_active <= 1'b0;
      tx_line   <= 1'b1;
      tx_pop    <= 1'b0;
      sh        <= '1;
      left      <= '0;
      tc        <= '0;
    end else begin
      tx_pop <= 1'b0;
      if (can_load) begin
        sh        <= frame;
        left      <= flen;
        tc        <= '0;
        tx_line   <= 1'b0;
        tx_active <= 1'b1;
        tx_pop    <= 1'b1;
      end else if (tick && tx_active) begin
        tc <= (tc == CW'(OS - 1)) ? '0 : tc + 1'b1;
        if (bit_end) begin
          if (left == NW'(1)) begin
            tx_active <= 1'b0;
            tx_line   <= 1'b1;
          end else begin
            sh      <= {1'b1, sh[FW-1:1]};
            tx_line <= sh[1];
            left    <= left - 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_os8_rx.sv
module uart_os8_rx
  import uart_os8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OS   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  line_cfg_t     cfg,
  input  logic          rx_in,
  output logic          rx_push,
  output logic [DW-1:0] rx_data,
  output logic          rx_par_err,
  output logic          rx_frm_err,
  output logic          rx_brk,
  output logic          rx_active
);
  localparam int FW  = DW + 3;           // start + data + parity + 1 stop
  localparam int NW  = $clog2(FW + 1);
  localparam int CW  = $clog2(OS);
  localparam int SMP = OS / 2 - 1;       // counter value on the bit-centre tick

  logic [SYNC-1:0] sync_q;
  logic            s;
  rx_state_e       st;
  logic [CW-1:0]   tc;
  logic [NW-1:0]   idx;
  logic [NW-1:0]   dlen;
  logic [NW-1:0]   last_i;
  logic [DW-1:0]   acc;
  logic [DW-1:0]   dat_w;
  logic            pb;
  logic            any_hi;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], rx_in};
  end
  assign s = sync_q[SYNC-1];

  assign dlen      = cfg.data8 ? NW'(DW) : NW'(DW - 1);
  assign last_i    = dlen + NW'(1) + NW'(cfg.par_en);
  assign dat_w     = cfg.data8 ? acc : {1'b0, acc[DW-1:1]};
  assign rx_active = (st == RX_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      tc         <= '0;
      idx        <= '0;
      acc        <= '0;
      pb         <= 1'b0;
      any_hi     <= 1'b0;
      rx_push    <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      rx_brk     <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (tick && !s) begin
            st     <= RX_RUN;
            tc     <= '0;
            idx    <= '0;
            acc    <= '0;
            pb     <= 1'b0;
            any_hi <= 1'b0;
          end
        end
        RX_RUN: begin
          if (tick) begin
            tc <= (tc == CW'(OS - 1)) ? '0 : tc + 1'b1;
            if (tc == CW'(SMP)) begin
              idx <= idx + 1'b1;
              if (idx == '0) begin
                if (s) st <= RX_IDLE;          // false start
              end else if (idx <= dlen) begin
                acc    <= {s, acc[DW-1:1]};
                any_hi <= any_hi | s;
              end else if (idx < last_i) begin
                pb     <= s;
                any_hi <= any_hi | s;
              end else begin
                rx_push <= 1'b1;
                if (!any_hi && !s) begin
                  rx_brk     <= 1'b1;
                  rx_data    <= '0;
                  rx_par_err <= 1'b0;
                  rx_frm_err <= 1'b0;
                  st         <= RX_HOLD;
                end else begin
                  rx_brk     <= 1'b0;
                  rx_data    <= dat_w;
                  rx_par_err <= cfg.par_en && (pb != par_from_xor(^acc, cfg.par_mode));
                  rx_frm_err <= !s;
                  st         <= s ? RX_IDLE : RX_HOLD;
                end
              end
            end
          end
        end
        default: begin
          if (s) st <= RX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_os8_engine.sv
module uart_os8_engine
  import uart_os8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OS   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cfg_data8,
  input  logic          cfg_stop2,
  input  logic          cfg_par_en,
  input  logic [1:0]    cfg_par_mode,
  input  logic          cfg_loop,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_pop,
  output logic          tx_line,
  output logic          tx_active,
  input  logic          rx_line,
  output logic          rx_push,
  output logic [DW-1:0] rx_data,
  output logic          rx_par_err,
  output logic          rx_frm_err,
  output logic          rx_brk,
  output logic          rx_active
);
  line_cfg_t cfg;
  logic      rx_src;

  assign cfg.data8    = cfg_data8;
  assign cfg.stop2    = cfg_stop2;
  assign cfg.par_en   = cfg_par_en;
  assign cfg.par_mode = par_mode_e'(cfg_par_mode);

  // Loopback: the receiver hears the transmitter, the pin is ignored.
  assign rx_src = cfg_loop ? tx_line : rx_line;

  uart_os8_tx #(.DW(DW), .OS(OS)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cfg       (cfg),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_pop    (tx_pop),
    .tx_line   (tx_line),
    .tx_active (tx_active)
  );

  uart_os8_rx #(.DW(DW), .OS(OS), .SYNC(SYNC)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cfg        (cfg),
    .rx_in      (rx_src),
    .rx_push    (rx_push),
    .rx_data    (rx_data),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .rx_brk     (rx_brk),
    .rx_active  (rx_active)
  );

endmodule

// File: rtl/uart_os8_chk.sv
module uart_os8_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          cfg_data8,
  input logic          tx_line,
  input logic          tx_pop,
  input logic          tx_active,
  input logic          rx_push,
  input logic          rx_active,
  input logic [DW-1:0] rx_data,
  input logic          rx_par_err,
  input logic          rx_frm_err,
  input logic          rx_brk
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> tx_line);

  a_r2_line_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tx_line));

  a_r3_pop_after_tick: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> ($past(tick) && tx_active));

  a_r4_seven_bit_msb: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !cfg_data8) |-> !rx_data[DW-1]);

  a_r9_break_clean: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_brk) |-> (rx_data == '0 && !rx_par_err && !rx_frm_err));

  a_r12_rx_idle_at_push: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_active);

  a_r13_push_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);

endmodule

bind uart_os8_engine uart_os8_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .cfg_data8  (cfg_data8),
  .tx_line    (tx_line),
  .tx_pop     (tx_pop),
  .tx_active  (tx_active),
  .rx_push    (rx_push),
  .rx_active  (rx_active),
  .rx_data    (rx_data),
  .rx_par_err (rx_par_err),
  .rx_frm_err (rx_frm_err),
  .rx_brk     (rx_brk)
);

// File: tb/uart_os8_engine_bench.sv
`timescale 1ns/1ps
module uart_os8_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_data8 = 1'b1, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_loop = 1'b1;
  logic [1:0] cfg_par_mode = 2'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_drv = 1'b0;
  logic       tx_pop, tx_line, tx_active, rx_push, rx_par_err, rx_frm_err, rx_brk, rx_active;
  logic [7:0] rx_data;

  always #2 clk = ~clk;   // 250 MHz

  uart_os8_engine u_uart_os8_engine (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_data8(cfg_data8), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
    .cfg_par_mode(cfg_par_mode), .cfg_loop(cfg_loop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .tx_line(tx_line), .tx_active(tx_active), .rx_line(rx_drv),
    .rx_push(rx_push), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_active(rx_active)
  );

  typedef struct packed {
    logic [7:0] d;
    logic       p;
    logic       f;
    logic       b;
  } item_t;

  item_t expq[$];
  string tagq[$];
  logic [7:0] txq[$];
  int checks = 0;
  int fails = 0;
  int npush = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Tick every fourth clock: one bit = 32 clocks.
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  // Transmit queue model.
  initial begin
    forever begin
      @(negedge clk);
      if (tx_pop && txq.size() > 0) void'(txq.pop_front());
      tx_valid = (txq.size() > 0);
      tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
    end
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    item_t got, e;
    string t;
    if (!rst && rx_push) begin
      npush++;
      got = '{rx_data, rx_par_err, rx_frm_err, rx_brk};
      if (expq.size() == 0) begin
        chk(1'b0, "R13", "unexpected character", int'(got), 0);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(got == e, t, "character {data,par,frm,brk}", int'(got), int'(e));
      end
    end
  end

  function automatic logic pbit(input logic [7:0] d, input logic d8, input logic [1:0] m);
    logic [7:0] x = d;
    if (!d8) x[7] = 1'b0;
    case (m)
      2'd0: return ~(^x);
      2'd1: return ^x;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int mkframe(input logic [7:0] d, input logic d8, input logic pen,
                                 input logic [1:0] m, input logic s2, input logic flip,
                                 input logic stopv, output logic [15:0] f);
    int n = 0;
    f = '1;
    f[n] = 1'b0; n = n + 1;
    for (int i = 0; i < (d8 ? 8 : 7); i++) begin
      f[n] = d[i]; n = n + 1;
    end
    if (pen) begin
      f[n] = pbit(d, d8, m) ^ flip; n = n + 1;
    end
    f[n] = stopv; n = n + 1;
    if (s2) begin
      f[n] = 1'b1; n = n + 1;
    end
    return n;
  endfunction

  task automatic set_cfg(input logic d8, input logic s2, input logic pen, input logic [1:0] m);
    @(negedge clk);
    cfg_data8 = d8; cfg_stop2 = s2; cfg_par_en = pen; cfg_par_mode = m;
  endtask

  task automatic expect_item(input logic [7:0] d, input logic p, input logic f, input logic b,
                             input string tag);
    expq.push_back('{d, p, f, b});
    tagq.push_back(tag);
  endtask

  // Samples tx_line at each bit centre, then tx_active around the frame end.
  task automatic check_tx(input logic [15:0] f, input int n, input string tag);
    @(negedge tx_line);
    repeat (16) @(posedge clk);
    #1;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        repeat (32) @(posedge clk);
        #1;
      end
      chk(tx_line == f[i], tag, $sformatf("R2 tx bit %0d", i), int'(tx_line), int'(f[i]));
    end
    repeat (14) @(posedge clk);
    #1 chk(tx_active == 1'b1, "R12", "tx_active before frame end", int'(tx_active), 1);
    repeat (4) @(posedge clk);
    #1 chk(tx_active == 1'b0, "R12", "tx_active after frame end", int'(tx_active), 0);
  endtask

  task automatic wait_drain(input string tag);
    int k = 0;
    while (expq.size() > 0 && k < 4000) begin
      @(negedge clk);
      k++;
    end
    chk(expq.size() == 0, tag, "characters still outstanding", expq.size(), 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic loop_byte(input logic [7:0] d, input string tag);
    logic [15:0] f;
    int n;
    n = mkframe(d, cfg_data8, cfg_par_en, cfg_par_mode, cfg_stop2, 1'b0, 1'b1, f);
    expect_item(cfg_data8 ? d : {1'b0, d[6:0]}, 1'b0, 1'b0, 1'b0, tag);
    fork
      check_tx(f, n, tag);
      txq.push_back(d);
    join
    wait_drain(tag);
    chk(txq.size() == 0, "R3", "transmit queue popped", txq.size(), 0);
  endtask

  task automatic bang(input logic [15:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rx_drv = f[i];
      repeat (32) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] f, g;
    int n, n2, p0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1", "tx_line after reset", int'(tx_line), 1);
    chk(tx_active == 1'b0 && rx_active == 1'b0, "R1", "active flags after reset",
        int'({tx_active, rx_active}), 0);
    chk(rx_push == 1'b0, "R1", "rx_push after reset", int'(rx_push), 0);
    repeat (20) @(negedge clk);

    // Loopback with the pin held low (R11 ignore).
    loop_byte(8'hA5, "R11");
    loop_byte(8'h01, "R3");

    // 7-bit words (R4).
    set_cfg(1'b0, 1'b0, 1'b0, 2'd0);
    loop_byte(8'hFF, "R4");
    loop_byte(8'h80, "R4");

    // Two stop bits (R5).
    set_cfg(1'b1, 1'b1, 1'b0, 2'd0);
    loop_byte(8'h3C, "R5");

    // All four parity modes (R6).
    for (int m = 0; m < 4; m++) begin
      set_cfg(1'b1, 1'b0, 1'b1, 2'(m));
      loop_byte(8'h03, "R6");
      loop_byte(8'h07, "R6");
    end
    set_cfg(1'b0, 1'b0, 1'b1, 2'd1);
    loop_byte(8'h55, "R6");

    // Back-to-back bytes (R3).
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    expect_item(8'h11, 1'b0, 1'b0, 1'b0, "R3");
    expect_item(8'h22, 1'b0, 1'b0, 1'b0, "R3");
    expect_item(8'h33, 1'b0, 1'b0, 1'b0, "R3");
    txq.push_back(8'h11); txq.push_back(8'h22); txq.push_back(8'h33);
    wait_drain("R3");

    // External line.
    @(negedge clk);
    rx_drv = 1'b1;
    repeat (8) @(negedge clk);
    cfg_loop = 1'b0;
    repeat (40) @(negedge clk);

    set_cfg(1'b1, 1'b0, 1'b1, 2'd1);
    n = mkframe(8'h5A, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, f);
    expect_item(8'h5A, 1'b0, 1'b0, 1'b0, "R7");
    fork
      bang(f, n);
      begin
        repeat (100) @(negedge clk);
        chk(rx_active == 1'b1, "R12", "rx_active mid-frame", int'(rx_active), 1);
      end
    join
    wait_drain("R7");
    n = mkframe(8'h5A, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, f);
    expect_item(8'h5A, 1'b1, 1'b0, 1'b0, "R7");
    bang(f, n);
    wait_drain("R7");
    set_cfg(1'b1, 1'b0, 1'b1, 2'd3);
    n = mkframe(8'hC3, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, f);
    expect_item(8'hC3, 1'b1, 1'b0, 1'b0, "R7");
    bang(f, n);
    wait_drain("R7");

    // Framing error (R8).
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    n = mkframe(8'h5A, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, f);
    expect_item(8'h5A, 1'b0, 1'b1, 1'b0, "R8");
    bang(f, n);
    wait_drain("R8");

    // Receiver with stop2 set accepts a frame right after one stop bit (R5).
    set_cfg(1'b1, 1'b1, 1'b0, 2'd0);
    n  = mkframe(8'h81, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, f);
    n2 = mkframe(8'h7E, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, g);
    expect_item(8'h81, 1'b0, 1'b0, 1'b0, "R5");
    expect_item(8'h7E, 1'b0, 1'b0, 1'b0, "R5");
    bang(f, n);
    bang(g, n2);
    wait_drain("R5");

    // Break: line low for 14 bit times, then a normal frame (R9).
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
    expect_item(8'h00, 1'b0, 1'b0, 1'b1, "R9");
    bang(16'h0000, 14);
    wait_drain("R9");
    n = mkframe(8'h96, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, f);
    expect_item(8'h96, 1'b0, 1'b0, 1'b0, "R9");
    bang(f, n);
    wait_drain("R9");

    // Short glitch is rejected (R10).
    p0 = npush;
    rx_drv = 1'b0;
    repeat (8) @(negedge clk);
    rx_drv = 1'b1;
    repeat (30) @(negedge clk);
    chk(rx_active == 1'b0, "R10", "rx_active after glitch", int'(rx_active), 0);
    repeat (400) @(negedge clk);
    chk(npush == p0, "R10", "pushes after glitch", npush - p0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule